// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block sits on the byte-wide receive stream of an Ethernet MAC and provides wake-on-LAN while the system is in a low-power state. Software programs the station MAC address, selects magic-packet wake and sets an enable bit. While the bit is set, every received frame is examined for a wake pattern and no frame byte is forwarded toward the host side. A frame qualifies when it holds a run of 0xFF bytes followed directly by sixteen back-to-back copies of the station address, and when it ends with a good CRC.

On a qualifying frame the block clears its own enable bit, sends a one-cycle wake pulse to the power controller and sets a sticky flag. It then keeps dropping traffic until the low-power status input falls, so nothing can pile up in receive buffers before the system is running again. If the system wakes by some other route and the enable bit is left set, traffic stays blocked until software clears the bit. Magic-packet wake cannot be active at the same time as the alternative pattern-based wake mode.

Top module: `mp_wake_det`

## Requirements
- R1: After reset the enable bit, the pattern-mode bit, the sticky flag and the wake pulse are all 0, and the receive stream is forwarded.
- R2: When the enable bit is 0 and no post-wake hold is active, every receive byte and its sof, eof and CRC markers appear on the forwarded outputs in the same cycle, unchanged.
- R3: While the enable bit is 1, fwd_valid stays 0 for every byte of every frame.
- R4: A wake frame holds six 0xFF bytes followed immediately by sixteen copies of the station address, each copy sent most significant byte first (address bits 47:40 first). The address is written with reg_addr 2 (wdata holds bits 31:0) and reg_addr 3 (wdata bits 15:0 hold bits 47:32).
- R5: A broken sequence restarts the search: a later 0xFF can begin a new sync run, more than six leading 0xFF bytes are accepted, and the pattern may begin at any byte of the frame.
- R6: A match is acted on only at the eof byte with rx_crc_ok high; a matching frame with a bad CRC raises no wake and leaves the enable bit set.
- R7: On a qualifying frame wake_irq is high for exactly the one cycle after the eof byte, and the enable bit reads 0 from that cycle on.
- R8: The sticky flag is set together with the wake pulse; writing reg_addr 4 with wdata bit 0 = 1 clears it, and writing bit 0 = 0 leaves it set.
- R9: After a wake, frames are dropped while low_power stays high; forwarding resumes from the cycle after low_power falls.
- R10: If the enable bit is still 1 after low_power falls, frames stay blocked until software writes reg_addr 0 with wdata bit 0 = 0.
- R11: reg_addr 0 bit 0 is the magic enable and reg_addr 1 bit 0 selects pattern mode; setting the enable while pattern mode is 1 is ignored, and setting pattern mode while the enable is 1 is ignored.
- R12: A frame with fewer than sixteen address copies after the sync run raises no wake and leaves the enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_crc_ok | input | 1 | CRC good, valid with rx_eof |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| low_power | input | 1 | System is in a low-power state |
| fwd_valid | output | 1 | Forwarded byte valid |
| fwd_data | output | 8 | Forwarded byte |
| fwd_sof | output | 1 | Forwarded first-byte marker |
| fwd_eof | output | 1 | Forwarded last-byte marker |
| fwd_crc_ok | output | 1 | Forwarded CRC-good marker |
| wake_irq | output | 1 | One-cycle wake pulse to the power controller |
| mp_enable | output | 1 | Current magic enable bit |
| pat_mode | output | 1 | Current pattern-mode select bit |
| wake_sticky | output | 1 | Sticky wake flag |

## Verification
A pattern counter left in a wrong state shows up only at the next eof byte with good CRC, as a missing or spurious wake pulse in the following cycle, so each scenario ends its frame and checks the pulse there. A wrong enable or hold bit shows within the same cycle as a forwarded or suppressed byte, which is why every byte of every frame is compared at the forwarded outputs. The register interlock is observed through the mode and enable outputs one cycle after each write.

// File: rtl/mp_wake_pkg.sv
package mp_wake_pkg;

  localparam logic [7:0] SYNC_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_MODE   = 3'd1,
    RA_MAC_LO = 3'd2,
    RA_MAC_HI = 3'd3,
    RA_STAT   = 3'd4
  } reg_sel_e;

  // byte k of the station address, most significant first
  function automatic logic [7:0] mac_byte(logic [47:0] mac, int k);
    return mac[(47 - 8 * k) -: 8];
  endfunction

  // one step of the pattern search; cnt counts matched bytes
  function automatic int mp_step(int cnt, logic [7:0] b, logic [47:0] mac,
                                 int sync_len, int total);
    int nxt;
    if (cnt >= total) begin
      nxt = total;
    end else if (cnt < sync_len) begin
      nxt = (b == SYNC_BYTE) ? cnt + 1 : 0;
    end else if (b == mac_byte(mac, (cnt - sync_len) % 6)) begin
      nxt = cnt + 1;
    end else if (b == SYNC_BYTE) begin
      nxt = (cnt == sync_len) ? sync_len : 1;
    end else begin
      nxt = 0;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/mp_matcher.sv
module mp_matcher
  import mp_wake_pkg::*;
#(
  parameter int SYNC_LEN  = 6,
  parameter int ADDR_REPS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic [47:0] mac,
  output logic        full_match
);
  localparam int TOTAL = SYNC_LEN + ADDR_REPS * 6;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  int            base;

  always_comb begin
    base  = in_sof ? 0 : int'(cnt_q);
    cnt_d = CW'(mp_step(base, in_data, mac, SYNC_LEN, TOTAL));
  end

  assign full_match = in_valid && (int'(cnt_d) == TOTAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (in_valid) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mp_ctrl.sv
module mp_ctrl
  import mp_wake_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        low_power,
  input  logic        detect,
  output logic        mp_en,
  output logic        pat_sel,
  output logic        sticky,
  output logic        hold,
  output logic        wake,
  output logic [47:0] mac
);
  logic wr_ctrl, wr_mode, wr_lo, wr_hi, wr_stat;

  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign wr_mode = reg_we && (reg_addr == RA_MODE);
  assign wr_lo   = reg_we && (reg_addr == RA_MAC_LO);
  assign wr_hi   = reg_we && (reg_addr == RA_MAC_HI);
  assign wr_stat = reg_we && (reg_addr == RA_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mp_en   <= 1'b0;
      pat_sel <= 1'b0;
      sticky  <= 1'b0;
      hold    <= 1'b0;
      wake    <= 1'b0;
      mac     <= '0;
    end else begin
      wake <= detect;
      if (detect)                 mp_en <= 1'b0;
      else if (wr_ctrl)           mp_en <= reg_wdata[0] && !pat_sel;
      if (wr_mode && !mp_en)      pat_sel <= reg_wdata[0];
      if (detect)                 sticky <= 1'b1;
      else if (wr_stat && reg_wdata[0]) sticky <= 1'b0;
      if (detect)                 hold <= 1'b1;
      else if (!low_power)        hold <= 1'b0;
      if (wr_lo)                  mac[31:0]  <= reg_wdata;
      if (wr_hi)                  mac[47:32] <= reg_wdata[15:0];
    end
  end
endmodule

// File: rtl/mp_rx_gate.sv
module mp_rx_gate (
  input  logic       block,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       in_crc_ok,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       out_crc_ok
);
  assign out_valid  = in_valid && !block;
  assign out_data   = in_data;
  assign out_sof    = in_sof;
  assign out_eof    = in_eof;
  assign out_crc_ok = in_crc_ok;
endmodule

// File: rtl/mp_wake_det.sv
module mp_wake_det #(
  parameter int SYNC_LEN  = 6,
  parameter int ADDR_REPS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_crc_ok,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        low_power,
  output logic        fwd_valid,
  output logic [7:0]  fwd_data,
  output logic        fwd_sof,
  output logic        fwd_eof,
  output logic        fwd_crc_ok,
  output logic        wake_irq,
  output logic        mp_enable,
  output logic        pat_mode,
  output logic        wake_sticky
);
  logic [47:0] mac;
  logic        full_match;
  logic        det_evt;
  logic        drop_hold;
  logic        block_rx;

  mp_matcher #(.SYNC_LEN(SYNC_LEN), .ADDR_REPS(ADDR_REPS)) u_match (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_data(rx_data),
    .in_sof(rx_sof), .mac(mac), .full_match(full_match)
  );

  assign det_evt  = full_match && rx_eof && rx_crc_ok && mp_enable;
  assign block_rx = mp_enable || drop_hold;

  mp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .low_power(low_power), .detect(det_evt),
    .mp_en(mp_enable), .pat_sel(pat_mode), .sticky(wake_sticky),
    .hold(drop_hold), .wake(wake_irq), .mac(mac)
  );

  mp_rx_gate u_gate (
    .block(block_rx), .in_valid(rx_valid), .in_data(rx_data),
    .in_sof(rx_sof), .in_eof(rx_eof), .in_crc_ok(rx_crc_ok),
    .out_valid(fwd_valid), .out_data(fwd_data), .out_sof(fwd_sof),
    .out_eof(fwd_eof), .out_crc_ok(fwd_crc_ok)
  );
endmodule

// File: rtl/mp_wake_chk.sv
module mp_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       rx_eof,
  input logic       rx_crc_ok,
  input logic       fwd_valid,
  input logic [7:0] fwd_data,
  input logic       wake_irq,
  input logic       mp_enable,
  input logic       pat_mode,
  input logic       wake_sticky,
  input logic       drop_hold
);
  // R7
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);
  // R7
  wake_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> !mp_enable);
  // R6
  wake_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> $past(rx_valid && rx_eof && rx_crc_ok));
  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> wake_sticky);
  // R3
  no_fwd_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mp_enable |-> !fwd_valid);
  // R9
  hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_hold |-> !fwd_valid);
  // R2
  fwd_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (rx_valid && fwd_data == rx_data));
  // R11
  excl_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mp_enable && pat_mode));
endmodule

bind mp_wake_det mp_wake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok), .fwd_valid(fwd_valid),
  .fwd_data(fwd_data), .wake_irq(wake_irq), .mp_enable(mp_enable),
  .pat_mode(pat_mode), .wake_sticky(wake_sticky), .drop_hold(drop_hold)
);

// File: tb/tb_mp_wake_det.sv
module tb_mp_wake_det;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        low_power = 1'b0;
  logic        fwd_valid, fwd_sof, fwd_eof, fwd_crc_ok;
  logic [7:0]  fwd_data;
  logic        wake_irq, mp_enable, pat_mode, wake_sticky;

  localparam logic [47:0] STN = 48'h02_1A_3B_4C_5D_6E;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] fb [0:255];
  int flen = 0;

  always #4 clk = ~clk;

  mp_wake_det dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic add(input logic [7:0] b);
    fb[flen] = b;
    flen++;
  endtask

  task automatic add_magic(input int reps, input int nsync);
    for (int i = 0; i < nsync; i++) add(8'hFF);
    for (int r = 0; r < reps; r++)
      for (int k = 0; k < 6; k++) add(STN[(47 - 8 * k) -: 8]);
  endtask

  // sends fb[0..flen-1]; checks forwarding per byte and the wake pulse
  task automatic send(input bit crc, input bit exp_pass, input bit exp_wake, input string tag);
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fb[i];
      rx_sof = (i == 0); rx_eof = (i == flen - 1); rx_crc_ok = crc && (i == flen - 1);
      #1;
      check(fwd_valid == exp_pass && (!exp_pass || (fwd_data == fb[i] &&
            fwd_sof == (i == 0) && fwd_eof == (i == flen - 1))),
            {tag, " fwd"}, int'(fwd_valid), int'(exp_pass));
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0;
    check(wake_irq == exp_wake, {tag, " wake"}, int'(wake_irq), int'(exp_wake));
    @(negedge clk);
    check(wake_irq == 1'b0, {tag, " pulse end"}, int'(wake_irq), 0);
    flen = 0;
  endtask

  task automatic t_reset();
    #1;
    check(mp_enable == 0 && pat_mode == 0 && wake_sticky == 0 && wake_irq == 0,
          "R1 reset state", {mp_enable, pat_mode, wake_sticky, wake_irq}, 0);
    add(8'h55); add(8'hAA); add(8'h01);
    send(1'b1, 1'b1, 1'b0, "R1 R2 passthrough");
  endtask

  task automatic t_program();
    wr(3'd2, STN[31:0]);
    wr(3'd3, {16'h0, STN[47:32]});
    wr(3'd0, 32'h1);
    low_power = 1'b1;
    check(mp_enable == 1, "R11 enable set", int'(mp_enable), 1);
    for (int i = 0; i < 20; i++) add(8'(i * 7 + 3));
    send(1'b1, 1'b0, 1'b0, "R3 other frame dropped");
    check(mp_enable == 1, "R3 enable kept", int'(mp_enable), 1);
  endtask

  task automatic t_bad_crc();
    add(8'h10); add_magic(16, 6); add(8'h20);
    send(1'b0, 1'b0, 1'b0, "R6 bad crc");
    check(mp_enable == 1 && wake_sticky == 0, "R6 enable kept", int'(mp_enable), 1);
  endtask

  task automatic t_short();
    add_magic(15, 6); add(8'h20);
    send(1'b1, 1'b0, 1'b0, "R12 15 copies");
    check(mp_enable == 1, "R12 enable kept", int'(mp_enable), 1);
  endtask

  task automatic t_detect();
    add(8'h11); add(8'hFF); add(8'hFF); add(8'h22);
    add_magic(16, 8); add(8'h33);
    send(1'b1, 1'b0, 1'b1, "R4 R5 R7 detect");
    check(mp_enable == 0, "R7 enable cleared", int'(mp_enable), 0);
    check(wake_sticky == 1, "R8 sticky set", int'(wake_sticky), 1);
  endtask

  task automatic t_hold();
    add(8'h44); add(8'h45);
    send(1'b1, 1'b0, 1'b0, "R9 held drop");
    @(negedge clk) low_power = 1'b0;
    @(negedge clk);
    add(8'h46); add(8'h47);
    send(1'b1, 1'b1, 1'b0, "R9 resume");
  endtask

  task automatic t_sticky();
    wr(3'd4, 32'h0);
    check(wake_sticky == 1, "R8 write 0 keeps", int'(wake_sticky), 1);
    wr(3'd4, 32'h1);
    check(wake_sticky == 0, "R8 write 1 clears", int'(wake_sticky), 0);
  endtask

  task automatic t_stale();
    wr(3'd0, 32'h1);
    low_power = 1'b1;
    @(negedge clk) low_power = 1'b0;
    @(negedge clk);
    add(8'h61); add(8'h62);
    send(1'b1, 1'b0, 1'b0, "R10 stale blocks");
    wr(3'd0, 32'h0);
    add(8'h63); add(8'h64);
    send(1'b1, 1'b1, 1'b0, "R10 cleared passes");
  endtask

  task automatic t_excl();
    wr(3'd1, 32'h1);
    check(pat_mode == 1, "R11 mode set", int'(pat_mode), 1);
    wr(3'd0, 32'h1);
    check(mp_enable == 0, "R11 enable ignored", int'(mp_enable), 0);
    add(8'h71);
    send(1'b1, 1'b1, 1'b0, "R11 still passes");
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h1);
    check(mp_enable == 1, "R11 enable ok", int'(mp_enable), 1);
    wr(3'd1, 32'h1);
    check(pat_mode == 0, "R11 mode ignored", int'(pat_mode), 0);
    wr(3'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_bad_crc();
    t_short();
    t_detect();
    t_hold();
    t_sticky();
    t_stale();
    t_excl();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule